// File: doc/BRIEF.md
# Fan Drive PWM Controller

This block generates a single fixed-period pulse-width signal for a two-wire cooling fan. Software programs it through two 32-bit words on a simple register bus. The control word carries a run bit, a wiring-mode bit and an 8-bit duty value. The speed word holds a 16-bit maximum-speed figure, which is stored and read back but does not shape the waveform. The period length is fixed at 40 ms and is derived from a clock-frequency parameter. Only the fraction of each period during which the output is high can be programmed.

The output goes high at the start of each period and stays high for a number of clock cycles proportional to the duty value. When the run bit is cleared, the output drops at once and the period position is discarded. Setting the run bit again starts a new period. A duty change made while running may give one period that blends the old and new values. Every later period uses the new value only.

Top module: `fanpwm_ctrl`

## Requirements
- R1: After a synchronous reset the output is low, the control word at offset 0x0 reads 0x00000000 and the speed word at offset 0x4 reads 0x00000FA0 (4000).
- R2: A write to offset 0x0 stores the run bit from bit 0, the wiring-mode bit from bit 1 and the duty value from bits 23:16. A read of 0x0 returns those fields in the same positions, with all other bits zero.
- R3: A write to offset 0x4 stores bits 15:0 as the maximum-speed value. A read of 0x4 returns it with bits 31:16 zero.
- R4: Any other address, including unaligned ones, reads as zero, and a write to it changes neither register.
- R5: While running, the output waveform repeats every PERIOD_TICKS cycles, where PERIOD_TICKS = (CLK_HZ/1000)*40.
- R6: In each full period the output is high for exactly floor(duty*PERIOD_TICKS/255) cycles. Duty 255 keeps it high for the whole period and duty 0 keeps it low.
- R7: The output is active high, and the high cycles form one run at the start of each period.
- R8: A write that clears the run bit drives the output low from the next cycle, and it stays low while the bit is clear.
- R9: A write that sets the run bit (from cleared) starts a new period whose first cycle begins right after the write.
- R10: After a duty change while running, every period that starts after the change follows only the new duty value.
- R11: With the wiring-mode bit set to 1 the output stays low. Mode 0 (two-wire) is the working mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fan_pwm | output | 1 | Fan drive output |

## Verification
The assertions assume that the register bus is driven with known values whenever reset is low, and that a write lasts exactly one cycle with its address and data stable around the sampling edge. The bench changes bus signals only on the falling clock edge and drops the strobe after a single cycle. Waveform properties assume CLK_HZ is a multiple of 1000, large enough for at least two ticks per period. The bench uses a small value of that kind so that full periods stay short.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned DUTY_W     = 8;
    localparam int unsigned SPEED_W    = 16;
    localparam int unsigned PERIOD_MS  = 40;
    localparam int unsigned DUTY_FULL  = 255;
    localparam int unsigned PROD_W     = 40;

    localparam logic [SPEED_W-1:0] SPEED_RST = 16'd4000;

    // Field placement inside the control word
    localparam int unsigned RUN_BIT    = 0;
    localparam int unsigned WIRE_BIT   = 1;
    localparam int unsigned DUTY_LSB   = 16;

    // Word offsets
    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_SPEED  = 4;

    typedef enum logic {
        WIRE_TWO  = 1'b0,
        WIRE_FOUR = 1'b1
    } wire_mode_e;

    typedef struct packed {
        logic              run;
        wire_mode_e        wiring;
        logic [DUTY_W-1:0] duty;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_SPEED = 2'd1,
        SEL_NONE  = 2'd2
    } reg_sel_e;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[RUN_BIT]                     = c.run;
        w[WIRE_BIT]                    = c.wiring;
        w[DUTY_LSB +: DUTY_W]          = c.duty;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.run    = w[RUN_BIT];
        c.wiring = wire_mode_e'(w[WIRE_BIT]);
        c.duty   = w[DUTY_LSB +: DUTY_W];
        return c;
    endfunction

    function automatic int unsigned period_ticks(input int unsigned clk_hz);
        return (clk_hz / 1000) * PERIOD_MS;
    endfunction

    function automatic logic [PROD_W-1:0] high_ticks(input logic [DUTY_W-1:0] duty,
                                                     input int unsigned       ticks);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(duty) * PROD_W'(ticks);
        return prod / PROD_W'(DUTY_FULL);
    endfunction

endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output ctrl_t              ctrl
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_SPEED = ADDR_W'(OFS_SPEED);

    ctrl_t              ctrl_q;
    logic [SPEED_W-1:0] speed_q;
    reg_sel_e           sel;
    logic               wdata_unused;

    assign wdata_unused = ^wdata[REG_W-1:DUTY_LSB+DUTY_W];

    always_comb begin
        if (addr == A_CTRL)
            sel = SEL_CTRL;
        else if (addr == A_SPEED)
            sel = SEL_SPEED;
        else
            sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            speed_q <= SPEED_RST;
        end else if (wr) begin
            case (sel)
                SEL_CTRL:  ctrl_q  <= unpack_ctrl(wdata);
                SEL_SPEED: speed_q <= wdata[SPEED_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  rdata = pack_ctrl(ctrl_q);
            SEL_SPEED: rdata = REG_W'(speed_q);
            default:   rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(speed_q))) // R4
        else $error("write to unmapped address changed a register");

    AST_STRAY_READ: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (rdata == '0)) // R4
        else $error("unmapped address returned non-zero data");

    AST_SPEED_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SPEED) |-> (rdata[REG_W-1:SPEED_W] == '0)) // R3
        else $error("speed word upper bits not zero");

endmodule

// File: rtl/fanpwm_period_ctr.sv
module fanpwm_period_ctr #(
    parameter int unsigned TICKS = 400,
    localparam int unsigned CNT_W = $clog2(TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    generate
        if (TICKS == (1 << CNT_W)) begin : g_pow2
            assign cnt_nx = cnt_q + 1'b1;
        end else begin : g_mod
            assign cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end

    assign cnt = cnt_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt_q} < (CNT_W+1)'(TICKS))) // R5
        else $error("period counter out of range");

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q == LAST) |=> (cnt_q == '0)) // R5
        else $error("period counter did not wrap");

    AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (cnt_q == '0)) // R9
        else $error("period did not restart on enable");

endmodule

// File: rtl/fanpwm_duty_cmp.sv
module fanpwm_duty_cmp
    import fanpwm_pkg::*;
#(
    parameter int unsigned TICKS = 400,
    localparam int unsigned CNT_W = $clog2(TICKS),
    localparam int unsigned THR_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]  cnt,
    output logic              pwm
);

    logic [THR_W-1:0] thr;

    assign thr = THR_W'(high_ticks(duty, TICKS));
    assign pwm = en && ({1'b0, cnt} < thr);

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (en && duty == '1) |-> pwm) // R6
        else $error("full duty did not hold output high");

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm) // R6
        else $error("zero duty produced a pulse");

    AST_PERIOD_HEAD: assert property (@(posedge clk) disable iff (rst)
        (en && duty != '0 && cnt == '0) |-> pwm) // R7
        else $error("period did not start high");

endmodule

// File: rtl/fanpwm_ctrl.sv
module fanpwm_ctrl
    import fanpwm_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned TICKS = period_ticks(CLK_HZ),
    localparam int unsigned CNT_W = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              fan_pwm
);

    ctrl_t            ctrl;
    logic             active;
    logic [CNT_W-1:0] cnt;

    fanpwm_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    assign active = ctrl.run && (ctrl.wiring == WIRE_TWO);

    fanpwm_period_ctr #(
        .TICKS (TICKS)
    ) u_period (
        .clk (clk),
        .rst (rst),
        .en  (active),
        .cnt (cnt)
    );

    fanpwm_duty_cmp #(
        .TICKS (TICKS)
    ) u_cmp (
        .clk  (clk),
        .rst  (rst),
        .en   (active),
        .duty (ctrl.duty),
        .cnt  (cnt),
        .pwm  (fan_pwm)
    );

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && !reg_wdata[RUN_BIT]) |=> !fan_pwm) // R8
        else $error("output not low after stop");

    AST_MODE_LOW: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[WIRE_BIT]) |=> !fan_pwm) // R11
        else $error("output active in unsupported wiring mode");

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !fan_pwm) // R1
        else $error("output not low after reset");

endmodule

// File: tb/fanpwm_ctrl_bench.sv
`timescale 1ns/1ps
module fanpwm_ctrl_bench;

    localparam int unsigned CLK_HZ = 10_000;
    localparam int          T      = (CLK_HZ / 1000) * 40;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        fan_pwm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_ctrl;
    logic [15:0] m_speed;

    fanpwm_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(4)) u_fanpwm_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fan_pwm   (fan_pwm)
    );

    always #10 clk = ~clk;

    function automatic int exp_high(input int d);
        return (d * T) / 255;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a == 4'h0) return m_ctrl;
        if (a == 4'h4) return {16'h0, m_speed};
        return 32'h0;
    endfunction

    function automatic logic [31:0] ctrl_word(input bit run, input bit mode, input int d);
        return {8'h0, 8'(d), 14'h0, mode, run};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        if (a == 4'h0) m_ctrl  = d & 32'h00FF_0003;
        if (a == 4'h4) m_speed = d[15:0];
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Samples one full period starting at the current negedge.
    task automatic measure(input int exp, input string req);
        int hi = 0;
        int pos_err = 0;
        for (int i = 0; i < T; i++) begin
            if (fan_pwm) hi++;
            if (fan_pwm !== (i < exp)) pos_err++;
            @(negedge clk);
        end
        check(hi == exp && pos_err == 0, req, longint'(hi) * 1000 + pos_err, longint'(exp) * 1000);
    endtask

    task automatic run_fresh(input int d);
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h0, ctrl_word(1'b1, 1'b0, d));
    endtask

    initial begin
        logic [31:0] v0, v4, va, r;
        int zeros;
        int d;
        logic [3:0] a;
        logic [31:0] wd;

        void'($urandom(32'd20240611));
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_ctrl = 32'h0; m_speed = 16'd4000;
        idle(4);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(fan_pwm == 1'b0, "R1 output after reset", fan_pwm, 0);
        rd_reg(4'h0, r);
        check(r == 32'h0, "R1 control word reset", r, 32'h0);
        rd_reg(4'h4, r);
        check(r == 32'h0000_0FA0, "R1 speed word reset", r, 32'h0FA0);

        // R2: directed full write
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0, r);
        check(r == 32'h00FF_0003, "R2 control fields", r, 32'h00FF_0003);

        // R3: speed word
        wr_reg(4'h4, 32'hABCD_1234);
        rd_reg(4'h4, r);
        check(r == 32'h0000_1234, "R3 speed field", r, 32'h1234);

        // R4: stray addresses
        wr_reg(4'h8, 32'h5555_5555);
        wr_reg(4'h2, 32'h0000_0000);
        wr_reg(4'hD, 32'hFFFF_0000);
        rd_reg(4'h0, v0);
        rd_reg(4'h4, v4);
        rd_reg(4'h8, va);
        check(v0 == 32'h00FF_0003 && v4 == 32'h1234 && va == 32'h0, "R4 stray writes ignored",
              {v0[23:0], v4[15:0], va[7:0]}, {24'hFF0003, 16'h1234, 8'h0});

        // R2 R3 R4: random register traffic against the model
        for (int k = 0; k < 40; k++) begin
            a  = 4'($urandom % 16);
            wd = $urandom;
            wr_reg(a, wd);
            rd_reg(4'h0, v0);
            rd_reg(4'h4, v4);
            rd_reg(a, va);
            check(v0 == model_read(4'h0) && v4 == model_read(4'h4) && va == model_read(a),
                  (a == 4'h0) ? "R2 random" : (a == 4'h4) ? "R3 random" : "R4 random",
                  va, model_read(a));
        end

        // R6 R7 R5: directed duties
        run_fresh(255);
        measure(exp_high(255), "R6 duty 255 full period");
        measure(exp_high(255), "R5 duty 255 repeat");
        run_fresh(0);
        measure(0, "R6 duty 0 stays low");
        run_fresh(1);
        measure(exp_high(1), "R7 duty 1 head pulse");
        run_fresh(128);
        measure(exp_high(128), "R6 duty 128 rounding down");
        run_fresh(254);
        measure(exp_high(254), "R6 duty 254");

        // R6 R5: random duties
        for (int k = 0; k < 10; k++) begin
            d = int'($urandom % 256);
            run_fresh(d);
            measure(exp_high(d), "R6 random duty");
            measure(exp_high(d), "R5 random duty repeat");
        end

        // R10: duty change mid-period
        run_fresh(64);
        measure(exp_high(64), "R10 before change");
        idle(150);
        wr_reg(4'h0, ctrl_word(1'b1, 1'b0, 200));
        idle(T - 151);
        measure(exp_high(200), "R10 first period after change");
        measure(exp_high(200), "R10 second period after change");

        // R8: stop mid-period
        run_fresh(255);
        idle(37);
        wr_reg(4'h0, ctrl_word(1'b0, 1'b0, 255));
        zeros = 0;
        for (int i = 0; i < 60; i++) begin
            if (fan_pwm == 1'b0) zeros++;
            @(negedge clk);
        end
        check(zeros == 60, "R8 low after stop", zeros, 60);

        // R9: restart gives a fresh period
        idle(13);
        wr_reg(4'h0, ctrl_word(1'b1, 1'b0, 100));
        measure(exp_high(100), "R9 fresh period after restart");

        // R11: wiring mode 1 keeps output low, mode 0 resumes
        wr_reg(4'h0, ctrl_word(1'b1, 1'b1, 200));
        measure(0, "R11 mode 1 low");
        wr_reg(4'h0, ctrl_word(1'b1, 1'b0, 200));
        measure(exp_high(200), "R11 mode 0 resumes");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule